// File: doc/BRIEF.md
# Serial Bus Device-Select Front End

This block sits at the edge of a two-wire serial memory slave (I2C-style bus). It watches the already synchronized clock and data line samples for a start condition. It then gathers the first byte that follows and decides whether this particular device is the one being addressed. The byte is accepted only if two checks pass. Its upper nibble must carry the fixed device-type code 1010. The next three bits must equal the levels on three pin-strapped chip-select inputs.

When the byte is accepted, the block pulls the data line low for the acknowledge clock. It also raises a selected flag and reports through a read/write flag whether the bus master asked to read or to write. Downstream memory logic uses these two flags. When either check fails, the block drops into standby, stays silent and ignores all bus traffic until the next start. A stop condition also returns the block to standby at any time.

Top module: `dsel_front`

## Requirements
- R1: After synchronous reset, sda_pull, selected and rd_req are all 0 and the block is in standby.
- R2: A start is SDA falling while SCL stays high. A start in any state (standby, mid-byte or after a completed selection) clears selected and rd_req and restarts reception of the address byte from its first bit.
- R3: Address bits are sampled on rising SCL edges, most significant bit first. The first 8 sampled bits after a start form the address byte, bit 7 first and bit 0 last.
- R4: The block acknowledges only when address byte bits 7:4 equal binary 1010.
- R5: The block acknowledges only when byte bit 3 equals strap[2], bit 2 equals strap[1] and bit 1 equals strap[0].
- R6: On a match, sda_pull and selected rise after the falling SCL edge that ends the 8th clock. sda_pull stays high through the 9th clock and drops after the falling edge of the 9th clock.
- R7: On a match, rd_req takes byte bit 0: 1 means a read request and 0 means a write request.
- R8: On a mismatch, sda_pull and selected stay 0. All further SCL clocks, including ones that carry a matching byte, have no effect until the next start.
- R9: A stop (SDA rising while SCL is high) clears selected, rd_req and sda_pull and returns the block to standby.
- R10: After a successful acknowledge, selected and rd_req hold their values across further SCL clocks until the next start or stop, and sda_pull stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized serial clock sample |
| sda_in | input | 1 | Synchronized serial data sample (wired bus level) |
| strap | input | 3 | Pin-strapped chip-select levels, strap[2] compared first |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| selected | output | 1 | This device was addressed and acknowledged |
| rd_req | output | 1 | Requested direction: 1 read, 0 write |

## Verification
The bench builds the block with its default parameters: a 4-bit type code of 1010 and three strap bits. With these values, every one of the eight strap settings can be reached and is drawn at random, and random bytes cover both type-code and strap mismatches. Directed sequences cover start conditions that cut a byte short, standby that ignores a later matching byte, and selections that end either in a stop or in a repeated start. The bench models the wired bus by combining its own data drive with the block's pull-low enable, so the acknowledge is visible on the line.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

    localparam int TYPE_W = 4;
    localparam int SEL_W  = 3;
    localparam int WORD_W = TYPE_W + SEL_W + 1;
    localparam logic [TYPE_W-1:0] TYPE_CODE = 4'b1010;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_ACK     = 2'd2,
        ST_ACTIVE  = 2'd3
    } sel_state_t;

    function automatic logic type_hits(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: TYPE_W] == TYPE_CODE;
    endfunction

    function automatic logic dir_bit(input logic [WORD_W-1:0] w);
        return w[0];
    endfunction

endpackage

// File: rtl/dsel_bus_cond.sv
module dsel_bus_cond
    import dsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.rise  = scl & ~scl_q;
        ev.fall  = ~scl & scl_q;
        ev.start = scl & scl_q & sda_q & ~sda;
        ev.stop  = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/dsel_shifter.sv
module dsel_shifter
    import dsel_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word,
    output logic         full
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            word <= '0;
        end else if (shift_en && !full) begin
            cnt  <= cnt + 1'b1;
            word <= {word[W-2:0], bit_in};
        end
    end

    assign full = (cnt == LAST);
endmodule

// File: rtl/dsel_ctrl.sv
module dsel_ctrl
    import dsel_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int W  = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [W-1:0]  word,
    input  logic          full,
    input  logic [SW-1:0] strap,
    output logic          shift_clr,
    output logic          shift_en,
    output logic          sda_pull,
    output logic          selected,
    output logic          rd_req
);
    sel_state_t    state;
    logic [SW-1:0] bit_eq;
    logic          hit;

    for (genvar i = 0; i < SW; i++) begin : g_cmp
        assign bit_eq[i] = ~(word[i+1] ^ strap[i]);
    end

    assign hit       = type_hits(word) & (&bit_eq);
    assign shift_clr = ev.start;
    assign shift_en  = ev.rise & (state == ST_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_STANDBY;
            sda_pull <= 1'b0;
            selected <= 1'b0;
            rd_req   <= 1'b0;
        end else if (ev.stop) begin
            state    <= ST_STANDBY;
            sda_pull <= 1'b0;
            selected <= 1'b0;
            rd_req   <= 1'b0;
        end else if (ev.start) begin
            state    <= ST_SHIFT;
            sda_pull <= 1'b0;
            selected <= 1'b0;
            rd_req   <= 1'b0;
        end else begin
            case (state)
                ST_SHIFT: begin
                    if (full && ev.fall) begin
                        if (hit) begin
                            state    <= ST_ACK;
                            sda_pull <= 1'b1;
                            selected <= 1'b1;
                            rd_req   <= dir_bit(word);
                        end else begin
                            state <= ST_STANDBY;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        state    <= ST_ACTIVE;
                        sda_pull <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dsel_front.sv
module dsel_front
    import dsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [SEL_W-1:0] strap,
    output logic             sda_pull,
    output logic             selected,
    output logic             rd_req
);
    bus_ev_t           ev;
    logic [WORD_W-1:0] word;
    logic              full;
    logic              shift_clr;
    logic              shift_en;

    dsel_bus_cond u_cond (
        .clk (clk),
        .rst (rst),
        .scl (scl_in),
        .sda (sda_in),
        .ev  (ev)
    );

    dsel_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (shift_clr),
        .shift_en (shift_en),
        .bit_in   (sda_in),
        .word     (word),
        .full     (full)
    );

    dsel_ctrl #(.SW(SEL_W), .W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .word      (word),
        .full      (full),
        .strap     (strap),
        .shift_clr (shift_clr),
        .shift_en  (shift_en),
        .sda_pull  (sda_pull),
        .selected  (selected),
        .rd_req    (rd_req)
    );
endmodule

// File: rtl/dsel_front_chk.sv
module dsel_front_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_in,
    input logic sda_pull,
    input logic selected,
    input logic rd_req
);
    logic scl_d;
    logic sda_d;
    logic st_seen;
    logic sp_seen;
    logic fall_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_in;
            sda_d <= sda_in;
        end
    end

    assign st_seen   = scl_in & scl_d & sda_d & ~sda_in;
    assign sp_seen   = scl_in & scl_d & ~sda_d & sda_in;
    assign fall_seen = scl_d & ~scl_in;

    p_pull_needs_sel_r6: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> selected);

    p_sel_rises_with_ack_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(selected) |-> sda_pull);

    p_ack_released_r6: assert property (@(posedge clk) disable iff (rst)
        (sda_pull && fall_seen) |=> !sda_pull);

    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        st_seen |=> (!selected && !sda_pull && !rd_req));

    p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
        sp_seen |=> (!selected && !sda_pull && !rd_req));

    p_dir_held_r10: assert property (@(posedge clk) disable iff (rst)
        (selected && $past(selected)) |-> $stable(rd_req));
endmodule

bind dsel_front dsel_front_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_pull (sda_pull),
    .selected (selected),
    .rd_req   (rd_req)
);

// File: tb/dsel_front_test.sv
`timescale 1ns/1ps
module dsel_front_test;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] strap = 3'b000;
    logic       sda_line;
    logic       sda_pull;
    logic       selected;
    logic       rd_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull;

    dsel_front uut (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .strap    (strap),
        .sda_pull (sda_pull),
        .selected (selected),
        .rd_req   (rd_req)
    );

    function automatic bit want_ack(input logic [7:0] b, input logic [2:0] s);
        return (b[7:4] == 4'b1010) && (b[3:1] == s);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic hold();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic do_start();
        sda_drv = 1'b1; hold();
        scl = 1'b1;     hold();
        sda_drv = 1'b0; hold();
        scl = 1'b0;     hold();
    endtask

    task automatic do_stop();
        sda_drv = 1'b0; hold();
        scl = 1'b1;     hold();
        sda_drv = 1'b1; hold();
    endtask

    task automatic do_bit(input logic b);
        sda_drv = b; hold();
        scl = 1'b1;  hold();
        scl = 1'b0;  hold();
    endtask

    // Sends a byte plus the 9th clock, checking the acknowledge window.
    task automatic do_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) do_bit(b[i]);
        chk({tag, " R6 pull after 8th fall"}, sda_pull, exp_ack);
        chk({tag, " R4/R5/R8 selected"}, selected, exp_ack);
        if (exp_ack) chk({tag, " R7 direction"}, rd_req, b[0]);
        sda_drv = 1'b1; hold();
        scl = 1'b1;     hold();
        chk({tag, " R6 pull held in 9th clock"}, sda_pull, exp_ack);
        chk({tag, " R6 line low in ack"}, sda_line, !exp_ack);
        scl = 1'b0;     hold();
        chk({tag, " R6 pull released"}, sda_pull, 1'b0);
        chk({tag, " R10 selected holds"}, selected, exp_ack);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset pull", sda_pull, 0);
        chk("R1 reset selected", selected, 0);
        chk("R1 reset rd", rd_req, 0);

        // Directed: write request match
        strap = 3'b101;
        do_start();
        do_byte(8'b1010_1010, 1, "R3 write");
        chk("R7 write flag", rd_req, 0);
        // R10: further clocks keep flags
        do_bit(1'b1); do_bit(1'b0); do_bit(1'b1);
        chk("R10 selected after data clocks", selected, 1);
        chk("R10 no pull after ack", sda_pull, 0);
        do_stop();
        chk("R9 stop clears selected", selected, 0);

        // Directed: read request, then repeated start clears
        strap = 3'b011;
        do_start();
        do_byte(8'b1010_0111, 1, "R7 read");
        chk("R7 read flag", rd_req, 1);
        do_start();
        chk("R2 start clears selected", selected, 0);
        chk("R2 start clears rd", rd_req, 0);
        do_byte(8'b1010_0110, 1, "R2 repeated start");
        do_stop();

        // Type mismatch, then matching byte in standby ignored
        strap = 3'b000;
        do_start();
        do_byte(8'b1011_0001, 0, "R4 bad type");
        do_byte(8'b1010_0001, 0, "R8 standby ignores");
        do_stop();

        // Strap mismatch
        strap = 3'b100;
        do_start();
        do_byte(8'b1010_0011, 0, "R5 bad strap");
        do_stop();

        // Start mid-byte restarts reception
        strap = 3'b010;
        do_start();
        do_bit(1'b0); do_bit(1'b1); do_bit(1'b1);
        do_start();
        do_byte(8'b1010_0101, 1, "R2 mid-byte restart");
        chk("R7 restart read flag", rd_req, 1);
        do_stop();
        chk("R9 stop after read", rd_req, 0);

        // Random transactions
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 60; n++) begin
            logic [7:0] b;
            bit exp;
            strap = 3'($urandom_range(0, 7));
            b = 8'($urandom);
            if ($urandom_range(0, 1) == 1) b[7:4] = 4'b1010;
            if ($urandom_range(0, 2) != 0) b[3:1] = strap;
            exp = want_ack(b, strap);
            do_start();
            do_byte(b, exp, "R4/R5 random");
            if ($urandom_range(0, 1) == 1) begin
                do_stop();
                chk("R9 random stop", selected, 0);
            end else begin
                do_start();
                chk("R2 random restart", selected, 0);
                do_stop();
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule